// File: doc/BRIEF.md
# Switch Forwarding Port-Mask Resolver

This block decides which egress ports of a small Ethernet switch receive a frame. A single table of port-group masks is read three times for each frame. The first read is by a destination index. The second is by a link-aggregation slot, which keeps one member of each aggregated link per flow. The third is by a source slot, which holds the forwarding permissions of the ingress port. The egress mask is the bitwise AND of the three words. Every mask has one bit per physical port, and one more bit, just above the last physical port, stands for the CPU port.

The destination index is taken from the MAC-table result when the lookup hits. On a miss it comes from the frame class: three writable flood-index registers cover unknown unicast, non-IP multicast and broadcast, and IPv4 and IPv6 multicast use fixed entries 62 and 63. Software fills the table and the flood registers through a simple write port.

Requests and results move on valid/ready streams. The pipeline is three stages deep and accepts one request per cycle. When a result is offered and `res_ready` is low, all stages freeze, the result holds, and `req_ready` drops until the result is taken.

Top module: `fwd_mask_resolver`

## Requirements
- R1: Reset clears every table entry to zero and deasserts `res_valid`. A frame sent before any configuration therefore resolves to an all-zero mask.
- R2: On a MAC hit (`req_mac_hit`=1) the destination entry is `req_mac_idx` (0..63), whatever the class.
- R3: On a miss, class code 0 (unknown unicast) uses the flood register at write address 92, code 1 (non-IP multicast) uses the one at address 93, and code 2 (broadcast) uses the one at address 94. Each flood register holds a 6-bit entry number in `cfg_wdata[5:0]`.
- R4: On a miss, class code 3 (IPv4 multicast) uses entry 62 and class code 4 (IPv6 multicast) uses entry 63. On a hit these codes have no effect.
- R5: The aggregation word is entry 64 + `req_agg_code` (entries 64..79).
- R6: The source word is entry 80 + `req_src_port` for ports below NPORTS. An ingress port number of NPORTS or more gives an all-zero source word.
- R7: `res_mask` is the bitwise AND of the destination, aggregation and source words. Bit j is egress port j, and bit NPORTS is the CPU port.
- R8: A request accepted in cycle n produces `res_valid` in cycle n+3 when `res_ready` stays high. Back-to-back requests are accepted one per cycle and come out in order.
- R9: While `res_valid` is high and `res_ready` is low, `res_mask` and `res_valid` hold and `req_ready` is low. Nothing is lost or reordered.
- R10: A write with `cfg_we` to address 0..91 replaces that table entry, and addresses 92..94 set the flood registers. Other addresses change nothing. A write applies to frames requested in later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 7 | Write address: table entry 0..91, flood registers 92..94 |
| cfg_wdata | input | 13 | Mask word, or flood entry number in bits 5:0 |
| req_valid | input | 1 | Frame request valid |
| req_ready | output | 1 | Request accepted when high together with valid |
| req_mac_hit | input | 1 | MAC-table lookup hit |
| req_mac_idx | input | 6 | Destination entry from the MAC table |
| req_class | input | 3 | Frame class: 0 UC, 1 MC, 2 BC, 3 IPv4 MC, 4 IPv6 MC |
| req_agg_code | input | 4 | Link aggregation code |
| req_src_port | input | 4 | Ingress port number |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Downstream accepts result |
| res_mask | output | 13 | Egress port mask, CPU bit on top |

## Verification
A request accepted at a clock edge produces its mask on the output three edges later. The driver records the cycle count on the falling edge before the accepting edge and pushes the expected mask with a due cycle three counts later. The monitor samples on falling edges, pops each result as it is taken and compares both the mask and the cycle. During the back-pressure test the due cycle is not checked. The bench instead checks on every falling edge of the stall that the held mask equals the head of the queue and that `req_ready` stays low. Configuration writes are kept at least one idle cycle away from frame requests.

// File: rtl/fwd_mask_pkg.sv
package fwd_mask_pkg;
  typedef enum logic [2:0] {
    FC_UCAST   = 3'd0,
    FC_MCAST   = 3'd1,
    FC_BCAST   = 3'd2,
    FC_IPV4_MC = 3'd3,
    FC_IPV6_MC = 3'd4
  } frame_class_e;

  localparam int DIDX_W    = 6;   // destination index width (entries 0..63)
  localparam int AGG_BASE  = 64;
  localparam int AGG_W     = 4;
  localparam int SRC_BASE  = 80;
  localparam int IPV4_ENTRY = 62;
  localparam int IPV6_ENTRY = 63;
endpackage

// File: rtl/fwd_flood_cfg.sv
module fwd_flood_cfg import fwd_mask_pkg::*; #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 13,
  parameter int BASE   = 92,
  parameter int UC_RST = 61,
  parameter int MC_RST = 60,
  parameter int BC_RST = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DIDX_W-1:0] flood_uc,
  output logic [DIDX_W-1:0] flood_mc,
  output logic [DIDX_W-1:0] flood_bc
);
  localparam logic [ADDR_W-1:0] A_UC = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] A_MC = ADDR_W'(BASE + 1);
  localparam logic [ADDR_W-1:0] A_BC = ADDR_W'(BASE + 2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flood_uc <= DIDX_W'(UC_RST);
      flood_mc <= DIDX_W'(MC_RST);
      flood_bc <= DIDX_W'(BC_RST);
    end else if (we) begin
      if (addr == A_UC) flood_uc <= wdata[DIDX_W-1:0];
      if (addr == A_MC) flood_mc <= wdata[DIDX_W-1:0];
      if (addr == A_BC) flood_bc <= wdata[DIDX_W-1:0];
    end
  end

  p_flood_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_UC) |=> flood_uc == $past(wdata[DIDX_W-1:0]));
endmodule

// File: rtl/fwd_dest_sel.sv
module fwd_dest_sel import fwd_mask_pkg::*; (
  input  logic              hit,
  input  logic [DIDX_W-1:0] mac_idx,
  input  logic [2:0]        cls,
  input  logic [DIDX_W-1:0] flood_uc,
  input  logic [DIDX_W-1:0] flood_mc,
  input  logic [DIDX_W-1:0] flood_bc,
  output logic [DIDX_W-1:0] dst_idx
);
  frame_class_e fc;
  assign fc = frame_class_e'(cls);

  always_comb begin
    if (hit) begin
      dst_idx = mac_idx;
    end else begin
      case (fc)
        FC_UCAST:   dst_idx = flood_uc;
        FC_BCAST:   dst_idx = flood_bc;
        FC_IPV4_MC: dst_idx = DIDX_W'(IPV4_ENTRY);
        FC_IPV6_MC: dst_idx = DIDX_W'(IPV6_ENTRY);
        default:    dst_idx = flood_mc;
      endcase
    end
  end
endmodule

// File: rtl/fwd_mask_table.sv
module fwd_mask_table #(
  parameter int ENTRIES = 92,
  parameter int MASK_W  = 13,
  parameter int IDX_W   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [MASK_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ra_idx,
  input  logic [IDX_W-1:0]  rb_idx,
  input  logic [IDX_W-1:0]  rc_idx,
  output logic [MASK_W-1:0] ra_mask,
  output logic [MASK_W-1:0] rb_mask,
  output logic [MASK_W-1:0] rc_mask
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [MASK_W-1:0] mem [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
    end else if (we && waddr <= LAST) begin
      mem[waddr] <= wdata;
    end
  end

  assign ra_mask = (ra_idx <= LAST) ? mem[ra_idx] : '0;
  assign rb_mask = (rb_idx <= LAST) ? mem[rb_idx] : '0;
  assign rc_mask = (rc_idx <= LAST) ? mem[rc_idx] : '0;

  p_entry_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (we && waddr <= LAST) |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/fwd_mask_resolver.sv
module fwd_mask_resolver import fwd_mask_pkg::*; #(
  parameter  int NPORTS  = 12,
  parameter  int PORT_W  = 4,
  localparam int MASK_W  = NPORTS + 1,
  localparam int ENTRIES = SRC_BASE + NPORTS,
  localparam int ADDR_W  = $clog2(ENTRIES + 3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [MASK_W-1:0] cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_mac_hit,
  input  logic [DIDX_W-1:0] req_mac_idx,
  input  logic [2:0]        req_class,
  input  logic [AGG_W-1:0]  req_agg_code,
  input  logic [PORT_W-1:0] req_src_port,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [MASK_W-1:0] res_mask
);
  localparam logic [PORT_W-1:0] PORT_LIM = PORT_W'(NPORTS);

  logic [DIDX_W-1:0] flood_uc, flood_mc, flood_bc, dst_idx;
  logic              stage_en;

  // stage 1: indices
  logic              s1_valid;
  logic [ADDR_W-1:0] s1_dst, s1_agg, s1_src;
  // stage 2: table words
  logic              s2_valid;
  logic [MASK_W-1:0] s2_dst, s2_agg, s2_src;
  logic [MASK_W-1:0] rd_dst, rd_agg, rd_src;

  assign stage_en  = !res_valid || res_ready;
  assign req_ready = stage_en;

  fwd_flood_cfg #(.ADDR_W(ADDR_W), .DATA_W(MASK_W), .BASE(ENTRIES)) u_flood (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .flood_uc(flood_uc), .flood_mc(flood_mc), .flood_bc(flood_bc)
  );

  fwd_dest_sel u_dsel (
    .hit(req_mac_hit), .mac_idx(req_mac_idx), .cls(req_class),
    .flood_uc(flood_uc), .flood_mc(flood_mc), .flood_bc(flood_bc),
    .dst_idx(dst_idx)
  );

  fwd_mask_table #(.ENTRIES(ENTRIES), .MASK_W(MASK_W), .IDX_W(ADDR_W)) u_tbl (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .waddr(cfg_addr), .wdata(cfg_wdata),
    .ra_idx(s1_dst), .rb_idx(s1_agg), .rc_idx(s1_src),
    .ra_mask(rd_dst), .rb_mask(rd_agg), .rc_mask(rd_src)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_dst    <= '0;
      s1_agg    <= '0;
      s1_src    <= '0;
      s2_valid  <= 1'b0;
      s2_dst    <= '0;
      s2_agg    <= '0;
      s2_src    <= '0;
      res_valid <= 1'b0;
      res_mask  <= '0;
    end else if (stage_en) begin
      s1_valid <= req_valid;
      s1_dst   <= ADDR_W'(dst_idx);
      s1_agg   <= ADDR_W'(AGG_BASE) + ADDR_W'(req_agg_code);
      s1_src   <= (req_src_port < PORT_LIM) ?
                  ADDR_W'(SRC_BASE) + ADDR_W'(req_src_port) : ADDR_W'(ENTRIES);
      s2_valid <= s1_valid;
      s2_dst   <= rd_dst;
      s2_agg   <= rd_agg;
      s2_src   <= rd_src;
      res_valid <= s2_valid;
      res_mask  <= s2_dst & s2_agg & s2_src;
    end
  end

  p_accept_fills_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> s1_valid);

  p_hit_index_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_mac_hit) |=> s1_dst == ADDR_W'($past(req_mac_idx)));

  p_ipv4_flood_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_mac_hit && req_class == 3'd3) |=> s1_dst == ADDR_W'(IPV4_ENTRY));

  p_src_index_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_src_port < PORT_LIM) |=>
      s1_src == ADDR_W'(SRC_BASE) + ADDR_W'($past(req_src_port)));

  p_hold_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_mask)));
endmodule

// File: tb/fwd_mask_resolver_bench.sv
module fwd_mask_resolver_bench;
  localparam int NP = 12;
  localparam int MW = NP + 1;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [6:0] cfg_addr = '0;
  logic [MW-1:0] cfg_wdata = '0;
  logic req_valid = 0, req_mac_hit = 0, res_ready = 1;
  logic [5:0] req_mac_idx = '0;
  logic [2:0] req_class = '0;
  logic [3:0] req_agg_code = '0, req_src_port = '0;
  logic req_ready, res_valid;
  logic [MW-1:0] res_mask;

  always #2.5 clk = ~clk;

  fwd_mask_resolver u_fwd_mask_resolver (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_mac_hit(req_mac_hit),
    .req_mac_idx(req_mac_idx), .req_class(req_class), .req_agg_code(req_agg_code),
    .req_src_port(req_src_port), .res_valid(res_valid), .res_ready(res_ready),
    .res_mask(res_mask)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [MW-1:0] mdl [0:127];
  int f_uc = 61, f_mc = 60, f_bc = 60;
  logic [MW-1:0] q_mask[$];
  int q_due[$];
  string q_tag[$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [MW-1:0] model(bit hit, int idx, int cls, int code, int port);
    int d;
    logic [MW-1:0] s;
    if (hit) d = idx;
    else case (cls)
      0: d = f_uc;
      2: d = f_bc;
      3: d = 62;
      4: d = 63;
      default: d = f_mc;
    endcase
    s = (port < NP) ? mdl[80 + port] : '0;
    return mdl[d] & mdl[64 + code] & s;
  endfunction

  // call just after a rising edge; returns just after a rising edge
  task automatic wr(int addr, logic [MW-1:0] data);
    cfg_we = 1; cfg_addr = 7'(addr); cfg_wdata = data;
    if (addr < 80 + NP) mdl[addr] = data;
    else if (addr == 92) f_uc = int'(data[5:0]);
    else if (addr == 93) f_mc = int'(data[5:0]);
    else if (addr == 94) f_bc = int'(data[5:0]);
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic send(bit hit, int idx, int cls, int code, int port, string tag, bit lat);
    req_valid = 1; req_mac_hit = hit; req_mac_idx = 6'(idx); req_class = 3'(cls);
    req_agg_code = 4'(code); req_src_port = 4'(port);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    q_mask.push_back(model(hit, idx, cls, code, port));
    q_due.push_back(lat ? cyc + 3 : -1);
    q_tag.push_back(tag);
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && res_valid && res_ready) begin
      if (q_mask.size() == 0) begin
        chk("R8 unexpected result", 32'(res_mask), 32'hFFFF_FFFF);
      end else begin
        automatic logic [MW-1:0] em = q_mask.pop_front();
        automatic int due = q_due.pop_front();
        automatic string tg = q_tag.pop_front();
        chk({tg, " mask"}, 32'(res_mask), 32'(em));
        if (due >= 0) chk({tg, " R8 latency"}, 32'(cyc), 32'(due));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) mdl[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 res_valid after reset", 32'(res_valid), 0);
    chk("R9 req_ready idle", 32'(req_ready), 1);
    @(posedge clk); #1;
    send(1, 4, 0, 0, 0, "R1 cleared table", 1);
    idle(5);

    // configuration
    for (int i = 0; i <= NP; i++) wr(i, MW'(1) << i);
    wr(40, 13'h000D);
    wr(59, 13'h1FFF);
    wr(60, 13'h10F3);
    wr(61, 13'h0FFF);
    wr(62, 13'h10AA);
    wr(63, 13'h0555);
    for (int c = 0; c < 16; c++) wr(64 + c, (c % 2 == 0) ? 13'h1FF7 : 13'h1FFB);
    for (int p = 0; p < NP; p++) wr(80 + p, (p == 5) ? 13'h100F : (13'h1FFF & ~(MW'(1) << p)));
    wr(92, 13'd61);
    wr(93, 13'd60);
    wr(94, 13'd59);
    idle(2);

    send(1, 4, 0, 0, 0, "R2 hit unicast", 1);           idle(1);
    send(1, 12, 0, 0, 0, "R7 hit cpu bit", 1);          idle(1);
    send(1, 0, 0, 0, 0, "R7 self excluded", 1);         idle(1);
    send(0, 0, 0, 0, 0, "R3 miss unicast", 1);          idle(1);
    send(0, 0, 1, 0, 0, "R3 miss multicast", 1);        idle(1);
    send(0, 0, 2, 0, 0, "R3 miss broadcast", 1);        idle(1);
    send(0, 0, 3, 0, 0, "R4 miss ipv4", 1);             idle(1);
    send(0, 0, 4, 0, 0, "R4 miss ipv6", 1);             idle(1);
    send(1, 40, 3, 0, 0, "R4 class ignored on hit", 1); idle(1);
    send(1, 40, 0, 1, 0, "R5 agg odd", 1);              idle(1);
    send(1, 40, 0, 15, 1, "R5 agg code 15", 1);         idle(1);
    send(0, 0, 2, 0, 5, "R6 restricted source", 1);     idle(1);
    send(0, 0, 2, 0, 13, "R6 port out of range", 1);    idle(1);
    send(0, 0, 2, 0, 12, "R6 port equals count", 1);    idle(4);

    // back-to-back stream
    for (int k = 0; k < 8; k++) send(k % 2, 40 + k, k % 5, k, k, "R8 stream", 1);
    idle(5);

    // back-pressure
    res_ready = 0;
    send(0, 0, 0, 0, 2, "R9 stall a", 0);
    send(0, 0, 3, 1, 3, "R9 stall b", 0);
    send(1, 5, 0, 2, 4, "R9 stall c", 0);
    repeat (4) begin
      @(negedge clk);
      chk("R9 held valid", 32'(res_valid), 1);
      chk("R9 ready low", 32'(req_ready), 0);
      chk("R9 held mask", 32'(res_mask), 32'(q_mask[0]));
    end
    @(posedge clk); #1;
    res_ready = 1;
    idle(6);

    // configuration changes
    wr(100, 13'h1FFF);
    idle(1);
    send(1, 4, 0, 0, 0, "R10 stray address ignored", 1); idle(1);
    wr(92, 13'd40);
    idle(1);
    send(0, 0, 0, 0, 0, "R10 flood reg rewrite", 1);     idle(1);
    wr(4, 13'h0030);
    idle(1);
    send(1, 4, 0, 0, 0, "R10 entry rewrite", 1);
    idle(8);
    chk("R8 all results drained", 32'(q_mask.size()), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule